// File: doc/BRIEF.md
# Redundant Comparator Selection Network

A flash converter built with spare comparators has more comparator outputs than thermometer levels. This block picks one comparator per level and turns the resulting thermometer word into a binary code. Each level draws from a window of neighbouring comparators. Windows of adjacent levels overlap, so one comparator may serve several levels, under a different local select code in each.

The block keeps a one-bit conversion enable per comparator and a select code per level, and a controller may rewrite both at any time while conversion runs. A separate address picks a single comparator for calibration. From it the block drives a one-hot calibration enable vector and returns that comparator's output. It also reports, per comparator, whether that comparator needs a clock at all.

Top module: `cmp_select_net`

## Requirements
- R1: After reset, comparator enables are set only at bank positions i·RED (the first candidate of each level i), every level select is 0, and `code_out` is 0.
- R2: `therm[i]` equals `cmp_out[i·RED + s]` AND the enable bit of that same comparator, where s is level i's select code; a selected but disabled comparator yields 0.
- R3: Comparator k is reached from level i with select code k − i·RED, so one comparator serves every level whose window covers it, each with its own code.
- R4: `code_out` is the number of ones in `therm`, registered: it shows the count of the `therm` value present at the previous rising clock edge.
- R5: With `en_wr` high, enable bit `en_idx` takes `en_val` at the next rising edge; an index of NCOMP or above leaves all enables unchanged, and with `en_wr` low the enables hold.
- R6: With `sel_wr` high, level `sel_lvl` takes select code `sel_val` at the next rising edge; a level of LEVELS or above, or a code of WIN or above, is ignored and all selects keep their values.
- R7: `cal_onehot` has bit `cal_addr` set and all others clear when `cal_en` is high and `cal_addr` < NCOMP; otherwise it is all zero.
- R8: `cal_bit` equals `cmp_out[cal_addr]` while `cal_onehot` is non-zero, and is 0 otherwise.
- R9: `clk_gate_en[k]` is 1 exactly when comparator k is enabled for conversion or selected for calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_out | input | NCOMP | Digital outputs of the comparator bank |
| en_wr | input | 1 | Enable register write strobe |
| en_idx | input | ADRW | Comparator index for the enable write |
| en_val | input | 1 | Enable value to write |
| sel_wr | input | 1 | Select register write strobe |
| sel_lvl | input | LVW | Level index for the select write |
| sel_val | input | SELW | Select code to write |
| cal_en | input | 1 | Calibration routing enable |
| cal_addr | input | ADRW | Comparator under calibration |
| therm | output | LEVELS | Thermometer word after level selection |
| code_out | output | NBITS | Registered binary code |
| conv_en | output | NCOMP | Conversion enable per comparator |
| cal_onehot | output | NCOMP | One-hot calibration enable per comparator |
| cal_bit | output | 1 | Output of the comparator under calibration |
| clk_gate_en | output | NCOMP | Clock needed per comparator |

## Verification
The assertions assume reset is asserted before the first edge and that write strobes, indices and values are stable around each rising edge. They also assume `cal_addr` may take any value, including the codes past the last comparator. The bench changes every input only on the falling edge, and it deliberately drives indices, levels and select codes that lie out of range. That way the ignore paths are exercised inside the assumptions rather than outside them.

// File: rtl/cmp_select_net.sv
module cmp_select_net #(
  parameter int NBITS = 3,
  parameter int RED   = 4,
  parameter int WIN   = 6,
  localparam int LEVELS = (1 << NBITS) - 1,
  localparam int NCOMP  = (LEVELS - 1) * RED + WIN,
  localparam int SELW   = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int ADRW   = $clog2(NCOMP),
  localparam int LVW    = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCOMP-1:0] cmp_out,
  input  logic             en_wr,
  input  logic [ADRW-1:0]  en_idx,
  input  logic             en_val,
  input  logic             sel_wr,
  input  logic [LVW-1:0]   sel_lvl,
  input  logic [SELW-1:0]  sel_val,
  input  logic             cal_en,
  input  logic [ADRW-1:0]  cal_addr,
  output logic [LEVELS-1:0] therm,
  output logic [NBITS-1:0] code_out,
  output logic [NCOMP-1:0] conv_en,
  output logic [NCOMP-1:0] cal_onehot,
  output logic             cal_bit,
  output logic [NCOMP-1:0] clk_gate_en
);

  function automatic logic [NCOMP-1:0] first_cands();
    logic [NCOMP-1:0] v;
    v = '0;
    for (int i = 0; i < LEVELS; i++) v[i*RED] = 1'b1;
    return v;
  endfunction

  localparam logic [NCOMP-1:0] DEF_EN = first_cands();

  logic [NCOMP-1:0] en_q;
  logic [SELW-1:0]  sel_q [LEVELS];
  logic [NBITS-1:0] ones;
  logic [NBITS-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= DEF_EN;
      for (int i = 0; i < LEVELS; i++) sel_q[i] <= '0;
    end else begin
      if (en_wr && int'(en_idx) < NCOMP) en_q[en_idx] <= en_val;
      if (sel_wr && int'(sel_lvl) < LEVELS && int'(sel_val) < WIN)
        sel_q[sel_lvl] <= sel_val;
    end
  end

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    logic [WIN-1:0] cand;
    assign cand     = cmp_out[i*RED +: WIN] & en_q[i*RED +: WIN];
    assign therm[i] = cand[sel_q[i]];
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < LEVELS; i++) ones = ones + NBITS'(therm[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= ones;
  end

  always_comb begin
    cal_onehot = '0;
    if (cal_en && int'(cal_addr) < NCOMP) cal_onehot[cal_addr] = 1'b1;
  end

  assign cal_bit     = |(cal_onehot & cmp_out);
  assign code_out    = code_q;
  assign conv_en     = en_q;
  assign clk_gate_en = en_q | cal_onehot;

endmodule

// File: rtl/cmp_select_net_chk.sv
module cmp_select_net_chk #(
  parameter int NBITS  = 3,
  parameter int LEVELS = 7,
  parameter int NCOMP  = 30,
  parameter int ADRW   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCOMP-1:0]  cmp_out,
  input logic              en_wr,
  input logic [ADRW-1:0]   en_idx,
  input logic              en_val,
  input logic              cal_en,
  input logic [ADRW-1:0]   cal_addr,
  input logic [LEVELS-1:0] therm,
  input logic [NBITS-1:0]  code_out,
  input logic [NCOMP-1:0]  conv_en,
  input logic [NCOMP-1:0]  cal_onehot,
  input logic              cal_bit,
  input logic [NCOMP-1:0]  clk_gate_en
);

  logic cal_ok;
  assign cal_ok = cal_en && int'(cal_addr) < NCOMP;

  // R7
  cal_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en |-> cal_onehot == '0);

  // R7
  cal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cal_onehot));

  // R8
  cal_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ok |-> cal_bit == cmp_out[cal_addr]);

  // R9
  cal_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ok |-> clk_gate_en[cal_addr]);

  // R9
  conv_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en & ~clk_gate_en) == '0);

  // R5
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && int'(en_idx) < NCOMP) |=> conv_en[$past(en_idx)] == $past(en_val));

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(conv_en));

  // R4
  enc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(code_out) == $countones($past(therm)));

endmodule

bind cmp_select_net cmp_select_net_chk #(
  .NBITS(NBITS), .LEVELS(LEVELS), .NCOMP(NCOMP), .ADRW(ADRW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_out(cmp_out), .en_wr(en_wr), .en_idx(en_idx),
  .en_val(en_val), .cal_en(cal_en), .cal_addr(cal_addr), .therm(therm),
  .code_out(code_out), .conv_en(conv_en), .cal_onehot(cal_onehot),
  .cal_bit(cal_bit), .clk_gate_en(clk_gate_en)
);

// File: tb/cmp_select_net_bench.sv
`timescale 1ns/1ps
module cmp_select_net_bench;
  localparam int NBITS = 3, RED = 4, WIN = 6;
  localparam int LEVELS = 7, NCOMP = 30, SELW = 3, ADRW = 5, LVW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCOMP-1:0] cmp_out = '0;
  logic en_wr = 0, en_val = 0, sel_wr = 0, cal_en = 0;
  logic [ADRW-1:0] en_idx = '0, cal_addr = '0;
  logic [LVW-1:0] sel_lvl = '0;
  logic [SELW-1:0] sel_val = '0;
  logic [LEVELS-1:0] therm;
  logic [NBITS-1:0] code_out;
  logic [NCOMP-1:0] conv_en, cal_onehot, clk_gate_en;
  logic cal_bit;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [NCOMP-1:0] en_m;
  int sel_m [LEVELS];

  always #2.5 clk = ~clk;

  cmp_select_net #(.NBITS(NBITS), .RED(RED), .WIN(WIN)) u_cmp_select_net (
    .clk(clk), .rst_n(rst_n), .cmp_out(cmp_out), .en_wr(en_wr), .en_idx(en_idx),
    .en_val(en_val), .sel_wr(sel_wr), .sel_lvl(sel_lvl), .sel_val(sel_val),
    .cal_en(cal_en), .cal_addr(cal_addr), .therm(therm), .code_out(code_out),
    .conv_en(conv_en), .cal_onehot(cal_onehot), .cal_bit(cal_bit),
    .clk_gate_en(clk_gate_en));

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [LEVELS-1:0] exp_therm(logic [NCOMP-1:0] c);
    logic [LEVELS-1:0] t;
    for (int i = 0; i < LEVELS; i++) t[i] = c[i*RED + sel_m[i]] & en_m[i*RED + sel_m[i]];
    return t;
  endfunction

  task automatic wr_en(int idx, logic v);
    @(negedge clk); en_wr = 1; en_idx = ADRW'(idx); en_val = v;
    @(negedge clk); en_wr = 0;
    if (idx < NCOMP) en_m[idx] = v;
  endtask

  task automatic wr_sel(int lvl, int v);
    @(negedge clk); sel_wr = 1; sel_lvl = LVW'(lvl); sel_val = SELW'(v);
    @(negedge clk); sel_wr = 0;
    if (lvl < LEVELS && v < WIN) sel_m[lvl] = v;
  endtask

  task automatic put_cmp(logic [NCOMP-1:0] c);
    @(negedge clk); cmp_out = c; #1;
  endtask

  task automatic t_reset();
    logic [NCOMP-1:0] d = '0;
    for (int i = 0; i < LEVELS; i++) d[i*RED] = 1'b1;
    en_m = d;
    for (int i = 0; i < LEVELS; i++) sel_m[i] = 0;
    chk("R1 enables", conv_en, d);
    chk("R1 code", code_out, 0);
    put_cmp(d);
    chk("R1 first candidates", therm, 7'h7f);
    put_cmp(~d);
    chk("R1 selects zero", therm, 0);
  endtask

  task automatic t_level_mux();
    logic [NCOMP-1:0] pats [4] = '{30'h15555555, 30'h2AAAAAAA, 30'h0F0F0F0F, 30'h3FFFFFFF};
    for (int p = 0; p < 4; p++) begin
      put_cmp(pats[p]);
      chk("R2 level pick", therm, exp_therm(pats[p]));
    end
    wr_en(8, 0);
    put_cmp('1);
    chk("R2 disabled selected", therm, 7'h7b);
    wr_en(8, 1);
    put_cmp('1);
    chk("R2 re-enabled", therm, 7'h7f);
  endtask

  task automatic t_shared();
    wr_sel(0, 4);
    put_cmp(30'h10);
    chk("R3 comparator 4 on two levels", therm, 7'h03);
    wr_en(5, 1);
    wr_sel(0, 5);
    wr_sel(1, 1);
    put_cmp(30'h20);
    chk("R3 comparator 5 on two levels", therm, 7'h03);
    wr_sel(0, 0); wr_sel(1, 0); wr_en(5, 0);
    put_cmp(30'h20);
    chk("R3 restored", therm, 0);
  endtask

  task automatic t_encoder();
    logic [NCOMP-1:0] pats [3] = '{30'h00000111, 30'h3FFFFFFF, 30'h01010101};
    for (int p = 0; p < 3; p++) begin
      logic [NBITS-1:0] prev = code_out;
      put_cmp(pats[p]);
      chk("R4 before edge", code_out, prev);
      @(posedge clk); #1;
      chk("R4 count", code_out, $countones(exp_therm(pats[p])));
    end
  endtask

  task automatic t_enable();
    @(negedge clk); en_wr = 1; en_idx = 3; en_val = 1; #1;
    chk("R5 not before edge", conv_en, en_m);
    @(posedge clk); #1;
    en_m[3] = 1;
    chk("R5 write at edge", conv_en, en_m);
    @(negedge clk); en_wr = 0;
    wr_en(31, 1);
    chk("R5 out of range ignored", conv_en, en_m);
    wr_en(3, 0);
    chk("R5 clear", conv_en, en_m);
  endtask

  task automatic t_select();
    wr_en(11, 1);
    wr_sel(2, 3);
    put_cmp(30'h800);
    chk("R6 select write", therm, 7'h04);
    wr_sel(2, 7);
    put_cmp(30'h800);
    chk("R6 code above window ignored", therm, 7'h04);
    wr_sel(7, 1);
    put_cmp('1);
    chk("R6 level out of range ignored", therm, exp_therm('1));
    wr_sel(2, 0); wr_en(11, 0);
    put_cmp(30'h100);
    chk("R6 restore", therm, 7'h04);
  endtask

  task automatic t_cal();
    int addrs [4] = '{0, 7, 17, 29};
    put_cmp(30'h2AAAAAAA);
    cal_en = 0; cal_addr = 5; #1;
    chk("R7 disabled onehot", cal_onehot, 0);
    chk("R8 disabled bit", cal_bit, 0);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); cal_en = 1; cal_addr = ADRW'(addrs[a]); #1;
      chk("R7 onehot", cal_onehot, 30'h1 << addrs[a]);
      chk("R8 routed bit", cal_bit, cmp_out[addrs[a]]);
      chk("R9 clock need", clk_gate_en, en_m | (30'h1 << addrs[a]));
    end
    @(negedge clk); cal_addr = 31; #1;
    chk("R7 address out of range", cal_onehot, 0);
    chk("R8 address out of range", cal_bit, 0);
    chk("R9 idle comparators off", clk_gate_en, en_m);
    @(negedge clk); cal_en = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_level_mux();
    t_shared();
    t_encoder();
    t_enable();
    t_select();
    t_cal();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule